// File: doc/BRIEF.md
# MDIO PHY Management Responder

This block plays the PHY side of an Ethernet management link whose pins are not real wires but bits in a host-writable pin register. The host toggles a clock bit, a data-out bit and an output-enable bit by writing that register, and reads back a data-in bit that the block drives. Every write that moves the clock bit from 0 to 1 counts as one management clock edge. On each such edge the block samples one bit, which is 1 only when data-out and output-enable are both set.

A run of 32 sampled ones arms the frame logic. The next 16 bits form the header, and the block checks and decodes it. A read frame fetches one of 32 sixteen-bit PHY registers and shifts it back on data-in, most significant bit first. A write frame is clocked through to its end but changes nothing. Two identification registers come out of reset with fixed values, and all the others read as zero. The PHY address field is never compared, so every address gets an answer.

Top module: `mdio_mgmt_responder`

## Requirements
- R1: Pin register layout: bit 0 data-out, bit 1 data-in, bit 2 output-enable, bit 3 clock. A host write loads bits 0, 2 and 3 from `host_wdata`, visible on `host_pins` the cycle after the write. A host write never changes bit 1.
- R2: A bit is sampled only on a host write that sets the clock bit while the stored clock bit is 0. The sampled value is data-out AND output-enable. A write that leaves the clock high, or writes it low, samples nothing, even if it changes data-out.
- R3: A frame is armed only after 32 consecutive sampled ones. Longer runs of ones keep it armed. With only 31 ones, the 16 bits that follow are not decoded.
- R4: The 16 header bits after the preamble arrive in this order: start (2 bits), opcode (2), PHY address (5), register address (5), turnaround (2). A read is accepted when start is 01, opcode is 10 and the second turnaround bit is 0.
- R5: On an accepted read, after the k-th rising clock edge that follows the header (k = 1..16), data-in shows bit 16-k of the addressed register.
- R6: A write is accepted only with start 01, opcode 01 and turnaround 10. It runs for 16 data edges and then returns to idle. The register file is unchanged, so a later read returns the reset value.
- R7: Any other start, opcode or turnaround ends the frame in idle. Data-in then holds its value through the following edges.
- R8: The PHY address field is not compared; a read answers for any of the 32 addresses.
- R9: After a frame has finished, or after reset, further clock edges without a fresh 32-ones preamble never start a frame.
- R10: Reset (synchronous, active high) clears the pin register and data-in to 0. It loads register 2 with 0x0022, register 3 with 0x161A and every other register with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle strobe: host writes the pin register |
| host_wdata | input | 4 | Value written to the pin register (bit 1 ignored) |
| host_pins | output | 4 | Pin register readback including driven data-in |

## Verification
The assertions assume that a clock edge comes only from a host write, and that the host does not drive 32 ones into the header window of a frame in progress. The bench keeps to this by building every management bit from two writes, clock low and then clock high, and by releasing output-enable or sending ordinary data after the header. Stalled writes that hold the clock high are inserted only to show that they are ignored. A reset is applied mid-frame only while data-in is being shifted out.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    // Pin register bit positions (host view)
    localparam int PIN_DO  = 0;
    localparam int PIN_DI  = 1;
    localparam int PIN_OE  = 2;
    localparam int PIN_CLK = 3;
    localparam int PIN_W   = 4;

    // Header geometry: bit positions counted from the newest sampled bit
    localparam int HDR_W     = 16;
    localparam int REG_AW    = 5;
    localparam int ST_HI     = 15;
    localparam int OP_HI     = 13;
    localparam int REG_LO    = 2;
    localparam int TA_HI     = 1;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_WRITE  = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;

    typedef enum logic [1:0] {
        MG_IDLE  = 2'd0,
        MG_READ  = 2'd1,
        MG_WRITE = 2'd2
    } mg_state_e;

    // One management clock event seen at the pin register
    typedef struct packed {
        logic rise;
        logic bit_v;
    } mg_edge_t;

    function automatic mg_state_e classify(input logic [1:0] st,
                                           input logic [1:0] op,
                                           input logic [1:0] ta);
        if (st == START_CODE && op == OPC_WRITE && ta == TA_WRITE)
            return MG_WRITE;
        if (st == START_CODE && op == OPC_READ && ta[0] == 1'b0)
            return MG_READ;
        return MG_IDLE;
    endfunction

endpackage

// File: rtl/mdio_pin_port.sv
module mdio_pin_port
    import mdio_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [PIN_W-1:0] host_wdata,
    input  logic             di_bit,
    output mg_edge_t         edge_o,
    output logic [PIN_W-1:0] pins_o
);
    localparam logic [PIN_W-1:0] DI_MASK = PIN_W'(1) << PIN_DI;

    logic [PIN_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (host_wr) begin
            ctrl_q <= host_wdata & ~DI_MASK;
        end
    end

    always_comb begin
        edge_o.rise  = host_wr && host_wdata[PIN_CLK] && !ctrl_q[PIN_CLK];
        edge_o.bit_v = host_wdata[PIN_DO] && host_wdata[PIN_OE];
        pins_o       = ctrl_q | (di_bit ? DI_MASK : '0);
    end

    // R2: a sampling edge needs a host write
    a_r2_edge_needs_write: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |-> host_wr);

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
    import mdio_resp_pkg::*;
#(
    parameter int SHIFT_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  mg_edge_t          edge_i,
    output mg_state_e         state_o,
    output logic              load_rd,
    output logic              shift_rd,
    output logic [REG_AW-1:0] reg_sel
);
    localparam int CNT_W = $clog2(SHIFT_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SHIFT_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

    logic [SHIFT_W-2:0] hist_q;
    logic [SHIFT_W-1:0] hist_n;
    logic [CNT_W-1:0]   cnt_q, cnt_eff, cnt_n;
    mg_state_e          state_q, state_n, verdict;
    logic               sync_hit, at_hdr, at_end;

    always_comb begin
        hist_n   = {hist_q, edge_i.bit_v};
        sync_hit = &hist_n;
        cnt_eff  = sync_hit ? CNT_FULL : cnt_q;
        at_hdr   = (cnt_eff == CNT_HDR);
        at_end   = (cnt_eff == '0);
        verdict  = classify(hist_n[ST_HI -: 2], hist_n[OP_HI -: 2], hist_n[TA_HI -: 2]);
        reg_sel  = hist_n[REG_LO +: REG_AW];

        // saturating down-count: an idle counter parks at zero
        cnt_n = at_end ? '0 : cnt_eff - 1'b1;

        state_n = state_q;
        if (at_hdr)
            state_n = verdict;
        else if (at_end)
            state_n = MG_IDLE;

        load_rd  = edge_i.rise && at_hdr && (verdict == MG_READ);
        shift_rd = edge_i.rise && (state_q == MG_READ) && (cnt_eff < CNT_HDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            cnt_q   <= '0;
            state_q <= MG_IDLE;
        end else if (edge_i.rise) begin
            hist_q  <= hist_n[SHIFT_W-2:0];
            cnt_q   <= cnt_n;
            state_q <= state_n;
        end
    end

    assign state_o = state_q;

    // R3: counter never exceeds the preamble length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    // R9: an active frame is always inside its data phase
    a_r9_active_in_data: assert property (@(posedge clk) disable iff (rst)
        (state_q != MG_IDLE) |-> (cnt_q < CNT_HDR));

    // R2: without a rising clock bit nothing in the decoder moves
    a_r2_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        !edge_i.rise |=> ($stable(cnt_q) && $stable(state_q)));

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
    import mdio_resp_pkg::*;
#(
    parameter int          DATA_W  = 16,
    parameter int          ID0_IDX = 2,
    parameter logic [15:0] ID0_VAL = 16'h0022,
    parameter int          ID1_IDX = 3,
    parameter logic [15:0] ID1_VAL = 16'h161A
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREGS = 1 << REG_AW;

    logic [DATA_W-1:0] regs_q [NREGS];

    // Writes from the management link are accepted but discarded.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                if (i == ID0_IDX)
                    regs_q[i] <= DATA_W'(ID0_VAL);
                else if (i == ID1_IDX)
                    regs_q[i] <= DATA_W'(ID1_VAL);
                else
                    regs_q[i] <= '0;
            end
        end
    end

    assign rdata = regs_q[raddr];

endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
    parameter int DATA_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              di_o
);
    logic [DATA_W-1:0] word_q;
    logic              di_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            di_q   <= 1'b0;
        end else if (load) begin
            word_q <= load_data;
        end else if (shift) begin
            di_q   <= word_q[DATA_W-1];
            word_q <= {word_q[DATA_W-2:0], 1'b0};
        end
    end

    assign di_o = di_q;

    // R5: load and shift never coincide
    a_r5_load_shift_excl: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/mdio_mgmt_responder.sv
module mdio_mgmt_responder
    import mdio_resp_pkg::*;
#(
    parameter int          SHIFT_W = 32,
    parameter int          DATA_W  = 16,
    parameter logic [15:0] ID0_VAL = 16'h0022,
    parameter logic [15:0] ID1_VAL = 16'h161A
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [3:0]       host_wdata,
    output logic [3:0]       host_pins
);
    mg_edge_t          edge_w;
    mg_state_e         state_w;
    logic              load_w, shift_w, di_w;
    logic [REG_AW-1:0] reg_w;
    logic [DATA_W-1:0] rdata_w;

    mdio_pin_port u_pins (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .di_bit     (di_w),
        .edge_o     (edge_w),
        .pins_o     (host_pins)
    );

    mdio_frame_decoder #(.SHIFT_W(SHIFT_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .edge_i   (edge_w),
        .state_o  (state_w),
        .load_rd  (load_w),
        .shift_rd (shift_w),
        .reg_sel  (reg_w)
    );

    mdio_phy_regs #(
        .DATA_W  (DATA_W),
        .ID0_VAL (ID0_VAL),
        .ID1_VAL (ID1_VAL)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .raddr (reg_w),
        .rdata (rdata_w)
    );

    mdio_read_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .load_data (rdata_w),
        .shift     (shift_w),
        .di_o      (di_w)
    );

    // R1: host bits land in the pin register one cycle after the write
    a_r1_host_bits: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (host_pins[PIN_CLK] == $past(host_wdata[PIN_CLK]) &&
                     host_pins[PIN_OE]  == $past(host_wdata[PIN_OE]) &&
                     host_pins[PIN_DO]  == $past(host_wdata[PIN_DO])));

    // R7: data-in only moves while a read frame is in its data phase
    a_r7_di_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_w != MG_READ) |=> $stable(host_pins[PIN_DI]));

endmodule

// File: tb/mdio_mgmt_responder_test.sv
module mdio_mgmt_responder_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [3:0] host_wdata;
    logic [3:0] host_pins;

    int tests  = 0;
    int fails  = 0;
    bit closed = 0;

    always #5 clk = ~clk;

    mdio_mgmt_responder uut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_pins  (host_pins)
    );

    // {preamble length, phy, reg, turnaround driven, expected}
    localparam logic [33:0] VEC [6] = '{
        {6'd32, 5'd1,  5'd2,  2'b00, 16'h0022},
        {6'd40, 5'd0,  5'd3,  2'b00, 16'h161A},
        {6'd32, 5'd31, 5'd3,  2'b10, 16'h161A},
        {6'd36, 5'd5,  5'd0,  2'b00, 16'h0000},
        {6'd32, 5'd17, 5'd31, 2'b00, 16'h0000},
        {6'd33, 5'd9,  5'd2,  2'b10, 16'h0022}
    };

    task automatic report;
        if (!closed) begin
            closed = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] v);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    // one management bit: clock low, then clock high; {clk, oe, di, do}
    task automatic bit_out(input logic d, input logic oe);
        hw({1'b0, oe, 1'b0, d});
        hw({1'b1, oe, 1'b0, d});
    endtask

    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) bit_out(1'b1, 1'b1);
    endtask

    // header bits, newest last; stall inserts a clock-high write with flipped data
    task automatic header(input logic [15:0] h, input bit stall);
        for (int i = 15; i >= 0; i--) begin
            bit_out(h[i], 1'b1);
            if (stall) hw({1'b1, 1'b1, 1'b0, ~h[i]});
        end
    endtask

    task automatic collect(output logic [15:0] v);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            bit_out(1'b0, 1'b0);
            v = {v[14:0], host_pins[1]};
        end
    endtask

    // clocks n edges and reports whether data-in ever left value ref
    task automatic quiet(input int n, input logic ref_v, output logic moved);
        moved = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_out(1'b0, 1'b0);
            if (host_pins[1] !== ref_v) moved = 1'b1;
        end
    endtask

    function automatic logic [15:0] hdr(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] ra,
                                        input logic [1:0] ta);
        return {st, op, phy, ra, ta};
    endfunction

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin
        logic [15:0] got;
        logic        moved, ref_v;

        rst = 1'b1; host_wr = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state of the pins
        chk("R10 reset pins", {12'd0, host_pins}, 16'h0000);

        // R1: bits 0,2,3 follow the write, bit 1 is not writable
        hw(4'b0111);
        chk("R1 pin write", {12'd0, host_pins}, 16'h0005);
        hw(4'b0010);
        chk("R1 di not writable", {12'd0, host_pins}, 16'h0000);

        // R4 R5 R8: table of reads over addresses and turnaround forms
        foreach (VEC[k]) begin
            preamble(int'(VEC[k][33:28]));
            header(hdr(2'b01, 2'b10, VEC[k][27:23], VEC[k][22:18], VEC[k][17:16]), 1'b0);
            collect(got);
            chk($sformatf("R5 R8 read vector %0d", k), got, VEC[k][15:0]);
        end

        // R2: stalled clock-high writes in the header are not sampled
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd4, 5'd3, 2'b00), 1'b1);
        collect(got);
        chk("R2 stalled writes ignored", got, 16'h161A);

        // R1: host write mid-read leaves data-in alone; R2: clock-low write is no edge
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd2, 5'd3, 2'b00), 1'b0);
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
        chk("R5 fourth data bit", {15'd0, host_pins[1]}, 16'h0001);
        hw(4'b0000);
        hw(4'b0101);
        chk("R1 di kept on host write", {15'd0, host_pins[1]}, 16'h0001);
        got = '0;
        for (int i = 0; i < 12; i++) begin
            bit_out(1'b0, 1'b0);
            got = {got[14:0], host_pins[1]};
        end
        chk("R2 no extra edge mid-read", got, 16'h061A);

        // R6: accepted write leaves the register unchanged
        preamble(32);
        header(hdr(2'b01, 2'b01, 5'd0, 5'd2, 2'b10), 1'b0);
        for (int i = 15; i >= 0; i--) bit_out(16'hBEEF >> i, 1'b1);
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b00), 1'b0);
        collect(got);
        chk("R6 write has no effect", got, 16'h0022);

        // R6: write with turnaround 01 rejected, link still usable
        preamble(32);
        header(hdr(2'b01, 2'b01, 5'd0, 5'd3, 2'b01), 1'b0);
        for (int i = 15; i >= 0; i--) bit_out(16'h1234 >> i, 1'b1);
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 1'b0);
        collect(got);
        chk("R6 after rejected write", got, 16'h161A);

        // R7: bad start code
        preamble(32);
        header(hdr(2'b00, 2'b10, 5'd0, 5'd3, 2'b00), 1'b0);
        ref_v = host_pins[1];
        quiet(16, ref_v, moved);
        chk("R7 bad start", {15'd0, moved}, 16'h0000);

        // R7: bad opcode
        preamble(32);
        header(hdr(2'b01, 2'b11, 5'd0, 5'd3, 2'b00), 1'b0);
        ref_v = host_pins[1];
        quiet(16, ref_v, moved);
        chk("R7 bad opcode", {15'd0, moved}, 16'h0000);

        // R7: read with turnaround bit 0 set
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b01), 1'b0);
        ref_v = host_pins[1];
        quiet(16, ref_v, moved);
        chk("R7 bad read turnaround", {15'd0, moved}, 16'h0000);

        // R9: no new frame after a finished read without preamble
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b00), 1'b0);
        collect(got);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 1'b0);
        ref_v = host_pins[1];
        quiet(16, ref_v, moved);
        chk("R9 no frame without preamble", {15'd0, moved}, 16'h0000);

        // R3: 31 ones are not a preamble
        bit_out(1'b0, 1'b1);
        preamble(31);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 1'b0);
        ref_v = host_pins[1];
        quiet(16, ref_v, moved);
        chk("R3 short preamble", {15'd0, moved}, 16'h0000);

        // R10 R9: reset in the middle of a read, then no frame resumes
        preamble(32);
        header(hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00), 1'b0);
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset mid-read", {12'd0, host_pins}, 16'h0000);
        quiet(20, 1'b0, moved);
        chk("R9 quiet after reset", {15'd0, moved}, 16'h0000);

        report();
    end

endmodule